// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block is the master end of a four-signal serial link to a small 512-byte EEPROM. The EEPROM is organised as 64 pages of 8 bytes. A host gives a 3-bit command code, a 9-bit address and a data byte, and pulses `start` for one cycle. The block opens a transaction by pulling chip select low. It then shifts out an opcode byte, an address byte where the command needs one, and the data bytes, while it collects any bytes the memory returns. When chip select rises again, `done` pulses for one cycle.

The block supports status read, status write, write-enable set, write-enable clear, single-byte read, single-byte write, and 8-byte page read and page write. Page data passes through an 8-entry buffer that the host loads and reads through an indexed port. The block never polls the memory's write cycle. A write command finishes as soon as its last bit has been sent, and the host finds completion with a later status read. Each command is one transaction, so a write-enable command is issued on its own, with chip select going high before the write that follows it.

The serial clock comes from a divider with `HALF_DIV` system cycles per phase. A mode input `shared_io` supports boards where one wire carries data in both directions: the block then releases its data output while the memory answers. The command sequencing is the same in both modes.

The controller runs through six named states:

| State | Description |
| --- | --- |
| IDLE | Waits for `start`. |
| LEAD | Chip select is low and the clock stays low for 2·HALF_DIV cycles. |
| LOW | The clock is low for HALF_DIV cycles. |
| HIGH | The clock is high for HALF_DIV cycles. |
| TRAIL | The clock is low for 2·HALF_DIV cycles after the last falling edge. |
| END | Chip select is high and `done` is high, for one cycle. |

The transitions are as follows:

- IDLE to LEAD on `start`.
- LEAD to LOW when the timer expires.
- LOW to HIGH when the timer expires. The input bit is sampled on this edge.
- HIGH to LOW when the timer expires and more bits remain. The next output bit is presented on this edge.
- HIGH to TRAIL when the timer expires on the last bit of the last byte.
- TRAIL to END when the timer expires.
- END to IDLE unconditionally.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: Host command codes map to opcode bytes as follows:
  - 0 (status read) sends 0x05.
  - 1 (status write) sends 0x01.
  - 2 (byte read) and 6 (page read) send 0x03.
  - 3 (byte write) and 7 (page write) send 0x02.
  - 4 (write-enable set) sends 0x06.
  - 5 (write-enable clear) sends 0x04.
- R2: For the four memory-data commands, address bit 8 is placed in bit 3 of the opcode byte. One byte holding address bits 7..0 follows the opcode.
- R3: Between transactions, `cs_n` is 1, `sck` is 0 and `sdo` is 1. This is also the state after reset.
- R4: Bits are sent and received most-significant bit first. `sdo` changes only while `sck` is low, and `sdi` is sampled when `sck` rises.
- R5: `sck` stays high for exactly HALF_DIV system cycles per bit. Chip select is low for at least 2·HALF_DIV cycles before the first rising edge, and stays low for at least 2·HALF_DIV cycles after the last falling edge.
- R6: The total byte count of a transaction, opcode and address byte included, depends on the command:
  - Write-enable set and write-enable clear send 1 byte.
  - Status read and status write send 2 bytes.
  - Byte read and byte write send 3 bytes.
  - Page read and page write send 10 bytes.
- R7: `done` is high for exactly one cycle, in the first cycle in which `cs_n` is high again. `busy` is high from the cycle after `start` is accepted until the transaction ends.
- R8: A `start` that arrives while `busy` is high is ignored. It does not change the running transaction and does not queue a second one.
- R9: Status write, byte write and page write end as soon as their last bit has been sent. A status read places the returned byte on `status`, and a byte read places it on `rdata`.
- R10: Page commands clear address bits 2..0 and move exactly 8 bytes. Page write sends buffer entries 0..7 in order. Page read stores the received bytes into entries 0..7 in order.
- R11: The host buffer port writes entry `buf_idx` when `buf_we` is high and the block is idle. A host write while `busy` is high is ignored. `buf_rdata` always shows entry `buf_idx`.
- R12: With `shared_io` at 0, `sdo_en` is always 1. With `shared_io` at 1, `sdo_en` is 0 during the data bytes of a read command and 1 at all other times.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a command |
| cmd | input | 3 | Host command code, as listed in R1 |
| addr | input | 9 | Byte address |
| wdata | input | 8 | Data for byte write or status write |
| shared_io | input | 1 | 1 selects single-wire bidirectional data |
| buf_we | input | 1 | Host write strobe for the page buffer |
| buf_idx | input | 3 | Page buffer entry select |
| buf_wdata | input | 8 | Host write data for the page buffer |
| buf_rdata | output | 8 | Page buffer entry at `buf_idx` |
| rdata | output | 8 | Byte returned by the last byte read |
| status | output | 8 | Byte returned by the last status read |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A transaction is in progress |
| cs_n | output | 1 | Active-low chip select |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data toward the memory |
| sdo_en | output | 1 | Output enable for `sdo` in shared mode |
| sdi | input | 1 | Serial data from the memory |

## Verification
Each kind of internal fault shows up at the ports in a different way:

- **Byte or bit counter error.** The number of `sck` rising edges in the transaction comes out wrong. The fault is visible at the chip-select rise that ends the transaction.
- **Shift-register or index error.** The returned `rdata`, `status` or buffer entries no longer match what the bench memory model holds. The fault is visible as soon as the value is read back.
- **Bad divider or timer count.** The high time of `sck` and the chip-select margins change. The fault is measured within the first transaction.
- **Wrong output-enable decode.** In shared mode, the block's own drive takes the place of the memory's answer on the shared wire. Every byte read after that returns 0xFF.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    typedef enum logic [2:0] {
        CMD_STAT_RD = 3'd0,
        CMD_STAT_WR = 3'd1,
        CMD_BYTE_RD = 3'd2,
        CMD_BYTE_WR = 3'd3,
        CMD_WEN_SET = 3'd4,
        CMD_WEN_CLR = 3'd5,
        CMD_PAGE_RD = 3'd6,
        CMD_PAGE_WR = 3'd7
    } host_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_TRAIL,
        ST_END
    } seq_state_e;

    // Opcode byte; bit 3 carries the top address bit for memory-data commands
    function automatic logic [7:0] op_byte(host_cmd_e c, logic a_top);
        logic [7:0] r;
        unique case (c)
            CMD_STAT_RD: r = 8'h05;
            CMD_STAT_WR: r = 8'h01;
            CMD_BYTE_RD,
            CMD_PAGE_RD: r = {4'h0, a_top, 3'b011};
            CMD_BYTE_WR,
            CMD_PAGE_WR: r = {4'h0, a_top, 3'b010};
            CMD_WEN_SET: r = 8'h06;
            CMD_WEN_CLR: r = 8'h04;
            default:     r = 8'hFF;
        endcase
        return r;
    endfunction

    function automatic logic needs_addr(host_cmd_e c);
        return (c == CMD_BYTE_RD) || (c == CMD_BYTE_WR) ||
               (c == CMD_PAGE_RD) || (c == CMD_PAGE_WR);
    endfunction

    function automatic logic is_rx_cmd(host_cmd_e c);
        return (c == CMD_STAT_RD) || (c == CMD_BYTE_RD) || (c == CMD_PAGE_RD);
    endfunction

    function automatic logic is_page_cmd(host_cmd_e c);
        return (c == CMD_PAGE_RD) || (c == CMD_PAGE_WR);
    endfunction

endpackage

// File: rtl/ee_phase_timer.sv
module ee_phase_timer #(
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expire
);

    logic [TW-1:0] cnt;

    assign expire = run && (cnt == limit - TW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + TW'(1);
        end
    end

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < limit)) else $error("phase counter beyond limit"); // R5

endmodule

// File: rtl/ee_page_store.sv
module ee_page_store #(
    parameter  int DEPTH = 8,
    parameter  int W     = 8,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_block,
    input  logic          host_we,
    input  logic [IW-1:0] host_idx,
    input  logic [W-1:0]  host_wdata,
    output logic [W-1:0]  host_rdata,
    input  logic          eng_we,
    input  logic [IW-1:0] eng_widx,
    input  logic [W-1:0]  eng_wdata,
    input  logic [IW-1:0] eng_ridx,
    output logic [W-1:0]  eng_rdata
);

    logic [DEPTH-1:0][W-1:0] mem;

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (eng_we && eng_widx == IW'(i)) begin
                mem[i] <= eng_wdata;
            end else if (host_we && !host_block && host_idx == IW'(i)) begin
                mem[i] <= host_wdata;
            end
        end
    end

    assign host_rdata = mem[host_idx];
    assign eng_rdata  = mem[eng_ridx];

    AST_HOST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_block && !eng_we) |=> $stable(mem)) else $error("buffer changed while blocked"); // R11

endmodule

// File: rtl/ee_seq.sv
module ee_seq
    import eeprom_pkg::*;
#(
    parameter  int HALF_DIV   = 2,
    parameter  int PAGE_BYTES = 8,
    parameter  int ADDR_W     = 9,
    localparam int IDXW       = $clog2(PAGE_BYTES),
    localparam int CNTW       = $clog2(PAGE_BYTES + 3),
    localparam int TW         = $clog2(2 * HALF_DIV + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              shared_io,
    input  logic              sdi,
    input  logic              tick,
    output logic              run,
    output logic [TW-1:0]     limit,
    output logic              eng_we,
    output logic [IDXW-1:0]   eng_widx,
    output logic [7:0]        eng_wdata,
    output logic [IDXW-1:0]   eng_ridx,
    input  logic [7:0]        eng_rdata,
    output logic              cs_n,
    output logic              sck,
    output logic              sdo,
    output logic              sdo_en,
    output logic [7:0]        rdata,
    output logic [7:0]        status,
    output logic              done,
    output logic              busy
);

    localparam logic [TW-1:0] LONG_PH  = TW'(2 * HALF_DIV);
    localparam logic [TW-1:0] SHORT_PH = TW'(HALF_DIV);

    seq_state_e        state, state_nx;
    host_cmd_e         cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        wdata_q;
    logic [7:0]        tx_sr;
    logic [7:0]        rx_sr;
    logic [2:0]        bit_cnt;
    logic [CNTW-1:0]   byte_idx;
    logic [CNTW-1:0]   nbytes_q;
    logic [CNTW-1:0]   hdr_q;
    logic [7:0]        next_tx;
    logic              last_bit;
    logic              byte_end;
    logic              in_data;

    function automatic logic [CNTW-1:0] total_bytes(host_cmd_e c);
        logic [CNTW-1:0] n;
        unique case (c)
            CMD_WEN_SET, CMD_WEN_CLR: n = CNTW'(1);
            CMD_STAT_RD, CMD_STAT_WR: n = CNTW'(2);
            CMD_BYTE_RD, CMD_BYTE_WR: n = CNTW'(3);
            CMD_PAGE_RD, CMD_PAGE_WR: n = CNTW'(PAGE_BYTES + 2);
            default:                  n = CNTW'(1);
        endcase
        return n;
    endfunction

    assign byte_end = (state == ST_HIGH) && tick && (bit_cnt == 3'd0);
    assign last_bit = byte_end && (byte_idx == nbytes_q - CNTW'(1));
    assign in_data  = (byte_idx >= hdr_q);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_LEAD;
            ST_LEAD:  if (tick)  state_nx = ST_LOW;
            ST_LOW:   if (tick)  state_nx = ST_HIGH;
            ST_HIGH:  if (tick)  state_nx = last_bit ? ST_TRAIL : ST_LOW;
            ST_TRAIL: if (tick)  state_nx = ST_END;
            ST_END:              state_nx = ST_IDLE;
            default:             state_nx = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        cs_n   = 1'b0;
        sck    = 1'b0;
        sdo    = tx_sr[7];
        sdo_en = 1'b1;
        done   = 1'b0;
        busy   = 1'b1;
        run    = 1'b0;
        limit  = SHORT_PH;
        unique case (state)
            ST_IDLE: begin
                cs_n = 1'b1;
                sdo  = 1'b1;
                busy = 1'b0;
            end
            ST_LEAD: begin
                run   = 1'b1;
                limit = LONG_PH;
            end
            ST_LOW, ST_HIGH: begin
                run = 1'b1;
                sck = (state == ST_HIGH);
                if (shared_io && is_rx_cmd(cmd_q) && in_data) sdo_en = 1'b0;
            end
            ST_TRAIL: begin
                run   = 1'b1;
                limit = LONG_PH;
                sdo   = 1'b1;
            end
            ST_END: begin
                cs_n = 1'b1;
                sdo  = 1'b1;
                done = 1'b1;
            end
            default: begin
                cs_n = 1'b1;
                sdo  = 1'b1;
            end
        endcase
    end

    // ---------------- buffer hookup and next byte ----------------
    assign eng_we    = byte_end && (cmd_q == CMD_PAGE_RD) && in_data;
    assign eng_widx  = IDXW'(byte_idx - CNTW'(2));
    assign eng_wdata = rx_sr;
    assign eng_ridx  = IDXW'(byte_idx - CNTW'(1));

    always_comb begin
        next_tx = 8'hFF;
        if (hdr_q == CNTW'(2) && byte_idx == CNTW'(0)) begin
            next_tx = addr_q[7:0];
        end else begin
            unique case (cmd_q)
                CMD_STAT_WR, CMD_BYTE_WR: next_tx = wdata_q;
                CMD_PAGE_WR:              next_tx = eng_rdata;
                default:                  next_tx = 8'hFF;
            endcase
        end
    end

    // ---------------- datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q    <= CMD_STAT_RD;
            addr_q   <= '0;
            wdata_q  <= '0;
            tx_sr    <= 8'hFF;
            rx_sr    <= '0;
            bit_cnt  <= '0;
            byte_idx <= '0;
            nbytes_q <= CNTW'(1);
            hdr_q    <= CNTW'(1);
            rdata    <= '0;
            status   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    cmd_q    <= host_cmd_e'(cmd);
                    addr_q   <= is_page_cmd(host_cmd_e'(cmd)) ?
                                {addr[ADDR_W-1:IDXW], IDXW'(0)} : addr;
                    wdata_q  <= wdata;
                    tx_sr    <= op_byte(host_cmd_e'(cmd), addr[ADDR_W-1]);
                    bit_cnt  <= 3'd7;
                    byte_idx <= '0;
                    nbytes_q <= total_bytes(host_cmd_e'(cmd));
                    hdr_q    <= needs_addr(host_cmd_e'(cmd)) ? CNTW'(2) : CNTW'(1);
                end
                ST_LOW: if (tick) begin
                    rx_sr <= {rx_sr[6:0], sdi};
                end
                ST_HIGH: if (tick) begin
                    if (bit_cnt != 3'd0) begin
                        tx_sr   <= {tx_sr[6:0], 1'b1};
                        bit_cnt <= bit_cnt - 3'd1;
                    end else begin
                        if (in_data && cmd_q == CMD_STAT_RD) status <= rx_sr;
                        if (in_data && cmd_q == CMD_BYTE_RD) rdata  <= rx_sr;
                        tx_sr    <= next_tx;
                        bit_cnt  <= 3'd7;
                        byte_idx <= byte_idx + CNTW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!sck && sdo)) else $error("idle line levels wrong"); // R3
    AST_SDO_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(sdo)) else $error("sdo moved while sck high"); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R7
    AST_DONE_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !$past(cs_n))) else $error("done not at cs rise"); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(cmd_q) && $stable(addr_q))) else $error("start accepted while busy"); // R8
    AST_FOUR_WIRE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !shared_io |-> sdo_en) else $error("sdo released in four-wire mode"); // R12
    AST_BYTE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (byte_idx <= nbytes_q)) else $error("byte index past count"); // R6

endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl #(
    parameter  int HALF_DIV   = 2,
    parameter  int PAGE_BYTES = 8,
    parameter  int ADDR_W     = 9,
    localparam int IDXW       = $clog2(PAGE_BYTES),
    localparam int TW         = $clog2(2 * HALF_DIV + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              shared_io,
    input  logic              buf_we,
    input  logic [IDXW-1:0]   buf_idx,
    input  logic [7:0]        buf_wdata,
    output logic [7:0]        buf_rdata,
    output logic [7:0]        rdata,
    output logic [7:0]        status,
    output logic              done,
    output logic              busy,
    output logic              cs_n,
    output logic              sck,
    output logic              sdo,
    output logic              sdo_en,
    input  logic              sdi
);

    logic            run;
    logic            tick;
    logic [TW-1:0]   limit;
    logic            eng_we;
    logic [IDXW-1:0] eng_widx;
    logic [IDXW-1:0] eng_ridx;
    logic [7:0]      eng_wdata;
    logic [7:0]      eng_rdata;

    ee_phase_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .limit  (limit),
        .expire (tick)
    );

    ee_page_store #(.DEPTH(PAGE_BYTES), .W(8)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_block (busy),
        .host_we    (buf_we),
        .host_idx   (buf_idx),
        .host_wdata (buf_wdata),
        .host_rdata (buf_rdata),
        .eng_we     (eng_we),
        .eng_widx   (eng_widx),
        .eng_wdata  (eng_wdata),
        .eng_ridx   (eng_ridx),
        .eng_rdata  (eng_rdata)
    );

    ee_seq #(.HALF_DIV(HALF_DIV), .PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd       (cmd),
        .addr      (addr),
        .wdata     (wdata),
        .shared_io (shared_io),
        .sdi       (sdi),
        .tick      (tick),
        .run       (run),
        .limit     (limit),
        .eng_we    (eng_we),
        .eng_widx  (eng_widx),
        .eng_wdata (eng_wdata),
        .eng_ridx  (eng_ridx),
        .eng_rdata (eng_rdata),
        .cs_n      (cs_n),
        .sck       (sck),
        .sdo       (sdo),
        .sdo_en    (sdo_en),
        .rdata     (rdata),
        .status    (status),
        .done      (done),
        .busy      (busy)
    );

endmodule

// File: tb/spi_eeprom_ctrl_test.sv
module spi_eeprom_ctrl_test;

    localparam int HALF = 2;
    localparam time TCK = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic [8:0] addr = 9'd0;
    logic [7:0] wdata = 8'd0;
    logic       shared_io = 1'b0;
    logic       buf_we = 1'b0;
    logic [2:0] buf_idx = 3'd0;
    logic [7:0] buf_wdata = 8'd0;
    logic [7:0] buf_rdata, rdata, status;
    logic       done, busy, cs_n, sck, sdo, sdo_en, sdi;

    always #(TCK / 2) clk = ~clk;

    spi_eeprom_ctrl #(.HALF_DIV(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .addr(addr),
        .wdata(wdata), .shared_io(shared_io), .buf_we(buf_we), .buf_idx(buf_idx),
        .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .rdata(rdata), .status(status),
        .done(done), .busy(busy), .cs_n(cs_n), .sck(sck), .sdo(sdo),
        .sdo_en(sdo_en), .sdi(sdi)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- memory device model ----------------
    logic [7:0] dev_mem [512];
    logic [7:0] ref_mem [512];
    logic [7:0] ref_buf [8];
    logic [7:0] dev_op, dev_sr, dev_out_sr;
    logic [8:0] dev_addr;
    logic       dev_wel = 1'b0, dev_wrote = 1'b0, dev_out = 1'b1;
    logic [1:0] dev_bp = 2'b00;
    int dev_bits = 0, dev_txn = 0, exp_nb = 0;
    time t_fall, t_first_rise, t_last_fall, t_rise, hi_min, hi_max;

    function automatic logic [7:0] init_val(int i);
        return 8'((i * 37 + 11) ^ (i >> 3));
    endfunction

    function automatic int bytes_for(logic [2:0] c);
        case (c)
            3'd4, 3'd5: return 1;
            3'd0, 3'd1: return 2;
            3'd2, 3'd3: return 3;
            default:    return 10;
        endcase
    endfunction

    assign sdi = shared_io ? (sdo_en ? sdo : dev_out) : dev_out;

    always @(negedge cs_n) begin
        dev_bits = 0;
        dev_out = 1'b1;
        t_fall = $time;
        hi_min = 1000000;
        hi_max = 0;
    end

    always @(posedge sck) if (!cs_n) begin
        if (dev_bits == 0) t_first_rise = $time;
        t_rise = $time;
        dev_sr = {dev_sr[6:0], sdo};
        dev_bits++;
        if (dev_bits % 8 == 0) begin
            if (dev_bits == 8) begin
                dev_op = dev_sr;
                if (dev_sr == 8'h06) dev_wel = 1'b1;
                if (dev_sr == 8'h04) dev_wel = 1'b0;
            end else if (dev_bits == 16 && (dev_op & 8'hF6) == 8'h02) begin
                dev_addr = {dev_op[3], dev_sr};
            end else if (dev_bits == 16 && dev_op == 8'h01) begin
                if (dev_wel) begin dev_bp = dev_sr[3:2]; dev_wrote = 1'b1; end
            end else if (dev_bits > 16 && (dev_op & 8'hF7) == 8'h02) begin
                if (dev_wel) begin dev_mem[dev_addr] = dev_sr; dev_wrote = 1'b1; end
                dev_addr = {dev_addr[8:3], dev_addr[2:0] + 3'd1};
            end
        end
    end

    always @(negedge sck) if (!cs_n) begin
        t_last_fall = $time;
        if ($time - t_rise < hi_min) hi_min = $time - t_rise;
        if ($time - t_rise > hi_max) hi_max = $time - t_rise;
        if ((dev_op == 8'h05 && dev_bits >= 8) ||
            ((dev_op & 8'hF7) == 8'h03 && dev_bits >= 16)) begin
            if (dev_bits % 8 == 0) begin
                if (dev_op == 8'h05) dev_out_sr = {4'h0, dev_bp, dev_wel, 1'b0};
                else begin dev_out_sr = dev_mem[dev_addr]; dev_addr = dev_addr + 9'd1; end
            end else begin
                dev_out_sr = {dev_out_sr[6:0], 1'b1};
            end
            dev_out = dev_out_sr[7];
        end
    end

    always @(posedge cs_n) if (rst_n) begin
        dev_txn++;
        if (dev_wrote) dev_wel = 1'b0;
        dev_wrote = 1'b0;
        dev_out = 1'b1;
        chk(dev_bits == 8 * exp_nb, "R6 clock edges per transaction", dev_bits, 8 * exp_nb);
        chk(t_first_rise - t_fall >= 2 * HALF * TCK, "R5 cs lead time",
            int'(t_first_rise - t_fall), 2 * HALF * TCK);
        chk($time - t_last_fall >= 2 * HALF * TCK, "R5 cs trail time",
            int'($time - t_last_fall), 2 * HALF * TCK);
        chk(hi_min == HALF * TCK && hi_max == HALF * TCK, "R5 sck high width",
            int'(hi_max), HALF * TCK);
    end

    // sdo only changes while sck low (R4), checked away from the edge
    logic sdo_prev = 1'b1;
    always @(negedge clk) begin
        if (rst_n && sck && sdo != sdo_prev)
            chk(1'b0, "R4 sdo changed with sck high", sdo, sdo_prev);
        if (rst_n && !shared_io && !sdo_en)
            chk(1'b0, "R12 four-wire released sdo", sdo_en, 1);
        sdo_prev = sdo;
    end

    // ---------------- host tasks ----------------
    task automatic run_cmd(input logic [2:0] c, input logic [8:0] a, input logic [7:0] d);
        bit prev_cs;
        @(negedge clk);
        start = 1'b1; cmd = c; addr = a; wdata = d; exp_nb = bytes_for(c);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R7 busy after start", busy, 1);
        prev_cs = cs_n;
        while (!done) begin prev_cs = cs_n; @(negedge clk); end
        chk(cs_n == 1'b1 && prev_cs == 1'b0, "R7 done at cs rise", {prev_cs, cs_n}, 2'b01);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R7 done single cycle", {done, busy}, 0);
    endtask

    task automatic host_wr(input int i, input logic [7:0] v);
        @(negedge clk);
        buf_we = 1'b1; buf_idx = 3'(i); buf_wdata = v;
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic host_rd(input int i, output logic [7:0] v);
        @(negedge clk);
        buf_idx = 3'(i);
        #1 v = buf_rdata;
    endtask

    task automatic byte_write(input logic [8:0] a, input logic [7:0] d);
        run_cmd(3'd4, 9'd0, 8'd0);
        run_cmd(3'd3, a, d);
        ref_mem[a] = d;
    endtask

    task automatic byte_read_check(input logic [8:0] a, input string tag);
        run_cmd(3'd2, a, 8'd0);
        chk(rdata == ref_mem[a], tag, rdata, ref_mem[a]);
    endtask

    task automatic page_write(input logic [8:0] a);
        for (int i = 0; i < 8; i++) host_wr(i, ref_buf[i]);
        run_cmd(3'd4, 9'd0, 8'd0);
        run_cmd(3'd7, a, 8'd0);
        for (int i = 0; i < 8; i++) ref_mem[{a[8:3], 3'(i)}] = ref_buf[i];
    endtask

    task automatic page_read_check(input logic [8:0] a, input string tag);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) host_wr(i, 8'h00);
        run_cmd(3'd6, a, 8'd0);
        for (int i = 0; i < 8; i++) begin
            host_rd(i, v);
            chk(v == ref_mem[{a[8:3], 3'(i)}], tag, v, ref_mem[{a[8:3], 3'(i)}]);
        end
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [7:0] v;
        int txn0;
        for (int i = 0; i < 512; i++) begin dev_mem[i] = init_val(i); ref_mem[i] = init_val(i); end
        void'($urandom(32'd24601));
        repeat (3) @(negedge clk);
        chk(cs_n == 1 && sck == 0 && sdo == 1 && done == 0 && busy == 0,
            "R3 reset line levels", {cs_n, sck, sdo, done, busy}, 5'b10100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R9: enable latch visible in status
        run_cmd(3'd4, 9'd0, 8'd0);
        run_cmd(3'd0, 9'd0, 8'd0);
        chk(status == 8'h02, "R1 R9 status after write-enable", status, 8'h02);
        run_cmd(3'd5, 9'd0, 8'd0);
        run_cmd(3'd0, 9'd0, 8'd0);
        chk(status == 8'h00, "R1 status after write-enable clear", status, 8'h00);
        run_cmd(3'd4, 9'd0, 8'd0);
        run_cmd(3'd1, 9'd0, 8'h0C);
        run_cmd(3'd0, 9'd0, 8'd0);
        chk(status == 8'h0C, "R9 status write then read", status, 8'h0C);
        chk(cs_n == 1 && sck == 0 && sdo == 1, "R3 idle levels between commands",
            {cs_n, sck, sdo}, 3'b101);

        // R2: top address bit in opcode
        byte_write(9'h1A5, 8'h3C);
        byte_write(9'h0A5, 8'hC3);
        byte_read_check(9'h1A5, "R2 R4 read upper half");
        byte_read_check(9'h0A5, "R2 R4 read lower half");
        byte_read_check(9'h1FF, "R2 last address");

        // R10: page aligned, buffer order
        for (int i = 0; i < 8; i++) ref_buf[i] = 8'(8'hA0 + i * 3);
        page_write(9'h13B);
        page_read_check(9'h13D, "R10 page read back");
        byte_read_check(9'h13C, "R10 page byte placement");
        byte_read_check(9'h140, "R10 neighbour page untouched");

        // R8: start during busy ignored
        txn0 = dev_txn;
        @(negedge clk);
        start = 1'b1; cmd = 3'd2; addr = 9'h0A5; exp_nb = 3;
        @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        start = 1'b1; cmd = 3'd4; addr = 9'h000;
        @(negedge clk); start = 1'b0;
        while (!done) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(dev_txn == txn0 + 1, "R8 only one transaction", dev_txn, txn0 + 1);
        chk(rdata == ref_mem[9'h0A5], "R8 running read intact", rdata, ref_mem[9'h0A5]);
        run_cmd(3'd0, 9'd0, 8'd0);
        chk(status[1] == 1'b0, "R8 enable not issued", status, 0);

        // R11: host buffer write during busy ignored
        @(negedge clk);
        start = 1'b1; cmd = 3'd6; addr = 9'h138; exp_nb = 10;
        @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        buf_we = 1'b1; buf_idx = 3'd2; buf_wdata = 8'hEE;
        @(negedge clk); buf_we = 1'b0;
        while (!done) @(negedge clk);
        host_rd(2, v);
        chk(v == ref_mem[9'h13A], "R11 host write while busy", v, ref_mem[9'h13A]);
        host_wr(5, 8'h5A);
        host_rd(5, v);
        chk(v == 8'h5A, "R11 host write while idle", v, 8'h5A);

        // R12: shared single-wire mode
        @(negedge clk); shared_io = 1'b1;
        byte_read_check(9'h1A5, "R12 shared byte read");
        page_read_check(9'h138, "R12 shared page read");
        run_cmd(3'd0, 9'd0, 8'd0);
        chk(status == 8'h0C, "R12 shared status read", status, 8'h0C);
        @(negedge clk); shared_io = 1'b0;

        // constrained random mix
        for (int k = 0; k < 30; k++) begin
            logic [8:0] ra;
            int sel;
            ra = 9'($urandom % 512);
            sel = int'($urandom % 3);
            @(negedge clk); shared_io = 1'($urandom % 2);
            if (sel == 0) begin
                byte_write(ra, 8'($urandom));
                byte_read_check(ra, "R9 random byte write/read");
            end else if (sel == 1) begin
                byte_read_check(ra, "R4 random byte read");
            end else begin
                for (int i = 0; i < 8; i++) ref_buf[i] = 8'($urandom);
                page_write(ra);
                page_read_check(ra, "R10 random page");
            end
        end

        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule